// File: doc/BRIEF.md
# Bus Activity Monitor with Watermark Interrupts

This block watches one bus channel and measures how busy it is. Every event pulse adds a programmable weight to a raw counter. The counter runs for a sampling period made of a programmable number of millisecond ticks. At the end of each period the raw total is folded into a running average by a shift-and-subtract filter, and the counter restarts from zero.

Interrupts come from two sources. The first is hysteresis on the raw count: the count must stay above an upper watermark, or below a lower one, for a programmed number of consecutive periods. The second is the average leaving a band set by two further watermarks. Each source sets a sticky status bit, and the interrupt line is high while any status bit whose enable is set remains high.

Software programs the monitor through a flat register port. It writes the watermarks, the weight, the initial average and the period. It then sets the enable bits in a packed control word and reacts to the level interrupt.

Top module: `acm_monitor`

## Requirements
- R1: Writes to control (0x00), upper watermark (0x04), lower watermark (0x08), initial average (0x0C), average upper watermark (0x10), average lower watermark (0x14), weight (0x18) and period (0x28, low 16 bits kept) read back at the same offset. An unmapped offset reads zero.
- R2: Each cycle with `bus_evt` high adds the weight to the raw count. At a period end the average becomes avg - (avg >> (K+1)) + (count >> (K+1)), with K taken from control bits 12:10, and the count restarts at zero. An event in the period-end cycle counts toward the next period.
- R3: A write to the initial-average register loads the running average, which reads at offset 0x20.
- R4: With value P in the period register, a period ends on the (P+1)-th `ms_tick` after sampling is enabled.
- R5: A period whose count is above the upper watermark advances a run counter, and any other period resets it. When the run reaches N it sets status bit 31 and restarts. N minus one sits in control bits 28:26.
- R6: The same rule applies to counts below the lower watermark. N minus one sits in control bits 25:23, and a completed run sets status bit 30.
- R7: At a period end, a new average above the average upper watermark sets status bit 29, and one below the average lower watermark sets status bit 28.
- R8: Status bits are sticky. Writing ones to offset 0x24 clears the matching bits, so all ones clears every bit.
- R9: `irq` is high when any of these enable and status pairs are both set: control bit 30 with status 31, control bit 29 with status 30, control bit 21 with status 29, control bit 20 with status 28.
- R10: Sampling runs only while control bit 31 (master enable) and bit 18 (periodic enable) are both set. Otherwise events and ticks are ignored, the count and tick position are cleared, the run counters are cleared, and the average holds.
- R11: After reset every register, the status and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bus_evt | input | 1 | One-cycle pulse per observed bus event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A wrong filter state or a wrong raw count shows up in the average readout at offset 0x20 right after the first period that uses it. It stays visible, because the error decays only by a factor of 1 - 2^-(K+1) per period. A wrong run counter or tick position shows up as a status bit that appears one period early or late, or never appears, in the status read just after the deciding tick. A leak of events while sampling is disabled appears in the average of the first period after sampling is re-enabled.

// File: rtl/acm_pkg.sv
package acm_pkg;

    localparam int DW = 32;
    localparam int AW = 6;
    localparam int PW = 16;
    localparam int NW = 3;

    localparam logic [AW-1:0] A_CTRL = 6'h00;
    localparam logic [AW-1:0] A_UP   = 6'h04;
    localparam logic [AW-1:0] A_LO   = 6'h08;
    localparam logic [AW-1:0] A_INIT = 6'h0C;
    localparam logic [AW-1:0] A_AUP  = 6'h10;
    localparam logic [AW-1:0] A_ALO  = 6'h14;
    localparam logic [AW-1:0] A_WGT  = 6'h18;
    localparam logic [AW-1:0] A_AVG  = 6'h20;
    localparam logic [AW-1:0] A_STAT = 6'h24;
    localparam logic [AW-1:0] A_PER  = 6'h28;

    localparam int SW = 4;

    typedef struct packed {
        logic            master;
        logic            periodic;
        logic            hi_run_ie;
        logic            lo_run_ie;
        logic            avg_hi_ie;
        logic            avg_lo_ie;
        logic [2:0]      k;
        logic [NW-1:0]   hi_need_m1;
        logic [NW-1:0]   lo_need_m1;
    } ctrl_t;

    typedef struct packed {
        logic hi_run;
        logic lo_run;
        logic avg_hi;
        logic avg_lo;
    } stat_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.master     = w[31];
        c.hi_run_ie  = w[30];
        c.lo_run_ie  = w[29];
        c.avg_hi_ie  = w[21];
        c.avg_lo_ie  = w[20];
        c.periodic   = w[18];
        c.k          = w[12:10];
        c.hi_need_m1 = w[28:26];
        c.lo_need_m1 = w[25:23];
        return c;
    endfunction

    function automatic stat_t stat_mask(input ctrl_t c);
        stat_t m;
        m.hi_run = c.hi_run_ie;
        m.lo_run = c.lo_run_ie;
        m.avg_hi = c.avg_hi_ie;
        m.avg_lo = c.avg_lo_ie;
        return m;
    endfunction

endpackage

// File: rtl/acm_period_timer.sv
module acm_period_timer #(
    parameter int PW = acm_pkg::PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [PW-1:0] period,
    output logic          period_end
);
    logic [PW-1:0] pos_q;

    assign period_end = run && tick && (pos_q == period);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos_q <= '0;
        end else if (tick) begin
            pos_q <= period_end ? '0 : pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/acm_event_accum.sv
module acm_event_accum #(
    parameter int DW = acm_pkg::DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          evt,
    input  logic [DW-1:0] weight,
    input  logic          period_end,
    output logic [DW-1:0] count_q
);
    logic [DW:0]   sum;
    logic [DW-1:0] sat_sum;

    always_comb begin
        sum     = {1'b0, count_q} + {1'b0, weight};
        sat_sum = sum[DW] ? '1 : sum[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
        end else if (period_end) begin
            count_q <= evt ? weight : '0;
        end else if (evt) begin
            count_q <= sat_sum;
        end
    end
endmodule

// File: rtl/acm_avg_filter.sv
module acm_avg_filter #(
    parameter int DW = acm_pkg::DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          update,
    input  logic [2:0]    k,
    input  logic [DW-1:0] sample,
    output logic [DW-1:0] avg_q,
    output logic [DW-1:0] avg_next
);
    logic [3:0] sh;

    always_comb begin
        sh       = {1'b0, k} + 4'd1;
        avg_next = avg_q - (avg_q >> sh) + (sample >> sh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            avg_q <= '0;
        end else if (load) begin
            avg_q <= load_val;
        end else if (update) begin
            avg_q <= avg_next;
        end
    end
endmodule

// File: rtl/acm_consec.sv
module acm_consec #(
    parameter int NW = acm_pkg::NW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          step,
    input  logic          hit,
    input  logic [NW-1:0] need_m1,
    output logic          fire,
    output logic [NW-1:0] run_q
);
    assign fire = step && hit && (run_q >= need_m1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            run_q <= '0;
        end else if (step) begin
            if (!hit || fire) run_q <= '0;
            else              run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/acm_monitor.sv
module acm_monitor #(
    parameter int DW = acm_pkg::DW,
    parameter int AW = acm_pkg::AW,
    parameter int PW = acm_pkg::PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ms_tick,
    input  logic          bus_evt,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq
);
    import acm_pkg::*;

    localparam int NW_L = acm_pkg::NW;

    logic [31:0]   ctrl_q;
    logic [DW-1:0] up_q, lo_q, init_q, aup_q, alo_q, wgt_q;
    logic [PW-1:0] per_q;
    stat_t         stat_q;
    ctrl_t         cfg;
    logic          run_en;
    logic          period_end;
    logic [DW-1:0] count_q;
    logic [DW-1:0] avg_q, avg_next;
    logic          hi_fire, lo_fire;
    logic [NW_L-1:0] up_run, dn_run;
    logic          wr_init, wr_stat;
    stat_t         set_v, clr_v;

    assign cfg     = decode_ctrl(ctrl_q);
    assign run_en  = cfg.master && cfg.periodic;
    assign wr_init = reg_we && (reg_addr == A_INIT);
    assign wr_stat = reg_we && (reg_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            up_q   <= '0;
            lo_q   <= '0;
            init_q <= '0;
            aup_q  <= '0;
            alo_q  <= '0;
            wgt_q  <= '0;
            per_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL: ctrl_q <= reg_wdata;
                A_UP:   up_q   <= reg_wdata[DW-1:0];
                A_LO:   lo_q   <= reg_wdata[DW-1:0];
                A_INIT: init_q <= reg_wdata[DW-1:0];
                A_AUP:  aup_q  <= reg_wdata[DW-1:0];
                A_ALO:  alo_q  <= reg_wdata[DW-1:0];
                A_WGT:  wgt_q  <= reg_wdata[DW-1:0];
                A_PER:  per_q  <= reg_wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    acm_period_timer #(.PW(PW)) u_timer (
        .clk(clk), .rst(rst), .run(run_en), .tick(ms_tick),
        .period(per_q), .period_end(period_end)
    );

    acm_event_accum #(.DW(DW)) u_accum (
        .clk(clk), .rst(rst), .run(run_en), .evt(bus_evt),
        .weight(wgt_q), .period_end(period_end), .count_q(count_q)
    );

    acm_avg_filter #(.DW(DW)) u_avg (
        .clk(clk), .rst(rst), .load(wr_init), .load_val(reg_wdata[DW-1:0]),
        .update(period_end), .k(cfg.k), .sample(count_q),
        .avg_q(avg_q), .avg_next(avg_next)
    );

    acm_consec #(.NW(NW_L)) u_hi_run (
        .clk(clk), .rst(rst), .run(run_en), .step(period_end),
        .hit(count_q > up_q), .need_m1(cfg.hi_need_m1),
        .fire(hi_fire), .run_q(up_run)
    );

    acm_consec #(.NW(NW_L)) u_lo_run (
        .clk(clk), .rst(rst), .run(run_en), .step(period_end),
        .hit(count_q < lo_q), .need_m1(cfg.lo_need_m1),
        .fire(lo_fire), .run_q(dn_run)
    );

    always_comb begin
        set_v.hi_run = hi_fire;
        set_v.lo_run = lo_fire;
        set_v.avg_hi = period_end && (avg_next > aup_q);
        set_v.avg_lo = period_end && (avg_next < alo_q);
        clr_v        = wr_stat ? stat_t'(reg_wdata[31:28]) : stat_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_v) | set_v;
    end

    assign irq = |(stat_q & stat_mask(cfg));

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata = ctrl_q;
            A_UP:   reg_rdata[DW-1:0] = up_q;
            A_LO:   reg_rdata[DW-1:0] = lo_q;
            A_INIT: reg_rdata[DW-1:0] = init_q;
            A_AUP:  reg_rdata[DW-1:0] = aup_q;
            A_ALO:  reg_rdata[DW-1:0] = alo_q;
            A_WGT:  reg_rdata[DW-1:0] = wgt_q;
            A_AVG:  reg_rdata[DW-1:0] = avg_q;
            A_STAT: reg_rdata[31:28]  = stat_q;
            A_PER:  reg_rdata[PW-1:0] = per_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/acm_monitor_chk.sv
module acm_monitor_chk (
    input logic                      clk,
    input logic                      rst,
    input logic                      reg_we,
    input logic [acm_pkg::AW-1:0]    reg_addr,
    input logic                      irq,
    input logic                      run_en,
    input logic [3:0]                stat_q,
    input logic [acm_pkg::DW-1:0]    avg_q,
    input logic [acm_pkg::DW-1:0]    count_q,
    input logic [acm_pkg::NW-1:0]    up_run
);
    import acm_pkg::*;

    // R9: the line may only be high while some status bit is set
    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q != 4'b0));

    // R10: no filter movement while sampling is off, unless software loads it
    p_avg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !(reg_we && reg_addr == A_INIT)) |=> $stable(avg_q));

    // R10: count cleared while sampling is off
    p_count_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (count_q == '0));

    // R8: status bits only fall on a status write
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == A_STAT) |=> (($past(stat_q) & ~stat_q) == 4'b0));

    // R5: a completed upper run restarts its counter
    p_run_restart_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[3]) |-> (up_run == '0));
endmodule

bind acm_monitor acm_monitor_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .irq(irq),
    .run_en(run_en), .stat_q(stat_q), .avg_q(avg_q), .count_q(count_q),
    .up_run(up_run)
);

// File: tb/acm_monitor_bench.sv
module acm_monitor_bench;
    import acm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0;
    logic        bus_evt = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #4 clk = ~clk;

    acm_monitor u_acm_monitor (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_evt(bus_evt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_ctrl = 0, m_up = 0, m_lo = 0, m_aup = 0, m_alo = 0, m_wgt = 0;
    logic [31:0] m_avg = 0;
    logic [3:0]  m_st = 0;
    int          m_hrun = 0, m_lrun = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input bit per,
        input bit hi_ie, input bit lo_ie, input bit ah_ie, input bit al_ie,
        input int k, input int hi_m1, input int lo_m1);
        logic [31:0] w = '0;
        w[31] = en; w[18] = per; w[30] = hi_ie; w[29] = lo_ie;
        w[21] = ah_ie; w[20] = al_ie;
        w[12:10] = k[2:0]; w[28:26] = hi_m1[2:0]; w[25:23] = lo_m1[2:0];
        return w;
    endfunction

    function automatic logic exp_irq();
        return (m_st[3] & m_ctrl[30]) | (m_st[2] & m_ctrl[29]) |
               (m_st[1] & m_ctrl[21]) | (m_st[0] & m_ctrl[20]);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            A_CTRL: begin
                m_ctrl = d;
                if (!(d[31] && d[18])) begin m_hrun = 0; m_lrun = 0; end
            end
            A_UP:   m_up = d;
            A_LO:   m_lo = d;
            A_AUP:  m_aup = d;
            A_ALO:  m_alo = d;
            A_WGT:  m_wgt = d;
            A_INIT: m_avg = d;
            A_STAT: m_st = m_st & ~d[31:28];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_evt = 1'b1;
        end
        @(negedge clk);
        bus_evt = 1'b0;
    endtask

    task automatic tick_once();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic step_model(input int n);
        longint prod = longint'(n) * longint'(m_wgt);
        logic [31:0] s = (prod > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : prod[31:0];
        int sh = int'(m_ctrl[12:10]) + 1;
        m_avg = m_avg - (m_avg >> sh) + (s >> sh);
        if (s > m_up) begin
            m_hrun++;
            if (m_hrun >= int'(m_ctrl[28:26]) + 1) begin m_st[3] = 1'b1; m_hrun = 0; end
        end else m_hrun = 0;
        if (s < m_lo) begin
            m_lrun++;
            if (m_lrun >= int'(m_ctrl[25:23]) + 1) begin m_st[2] = 1'b1; m_lrun = 0; end
        end else m_lrun = 0;
        if (m_avg > m_aup) m_st[1] = 1'b1;
        if (m_avg < m_alo) m_st[0] = 1'b1;
    endtask

    task automatic check_state(input string ctx);
        logic [31:0] v;
        rd(A_AVG, v);
        chk({"R2 average ", ctx}, v, m_avg);
        rd(A_STAT, v);
        chk({"R5 upper run status ", ctx}, {31'b0, v[31]}, {31'b0, m_st[3]});
        chk({"R6 lower run status ", ctx}, {31'b0, v[30]}, {31'b0, m_st[2]});
        chk({"R7 average band status ", ctx}, {30'b0, v[29:28]}, {30'b0, m_st[1:0]});
        chk({"R9 irq ", ctx}, {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        rd(A_CTRL, v); chk("R11 ctrl after reset", v, 0);
        rd(A_STAT, v); chk("R11 status after reset", v, 0);
        rd(A_AVG, v);  chk("R11 average after reset", v, 0);
        rd(A_PER, v);  chk("R11 period after reset", v, 0);
        chk("R11 irq after reset", {31'b0, irq}, 0);

        // R1 register readback
        wr(A_UP, 32'h1111_0004);   rd(A_UP, v);   chk("R1 upper wmark", v, 32'h1111_0004);
        wr(A_LO, 32'h2222_0008);   rd(A_LO, v);   chk("R1 lower wmark", v, 32'h2222_0008);
        wr(A_AUP, 32'h3333_0010);  rd(A_AUP, v);  chk("R1 avg upper", v, 32'h3333_0010);
        wr(A_ALO, 32'h4444_0014);  rd(A_ALO, v);  chk("R1 avg lower", v, 32'h4444_0014);
        wr(A_WGT, 32'h0000_0400);  rd(A_WGT, v);  chk("R1 weight", v, 32'h0000_0400);
        wr(A_PER, 32'h0001_2345);  rd(A_PER, v);  chk("R1 period low bits", v, 32'h0000_2345);
        wr(A_CTRL, 32'h2A5A_0C00); rd(A_CTRL, v); chk("R1 ctrl", v, 32'h2A5A_0C00);
        rd(6'h1C, v); chk("R1 unmapped offset", v, 0);

        // R3 initial average
        wr(A_INIT, 32'd777);
        rd(A_INIT, v); chk("R1 init readback", v, 32'd777);
        rd(A_AVG, v);  chk("R3 init loads average", v, 32'd777);

        // setup for main traffic
        wr(A_CTRL, 0);
        wr(A_WGT, 3); wr(A_UP, 20); wr(A_LO, 5);
        wr(A_AUP, 32'hFFFF_FFFF); wr(A_ALO, 0); wr(A_PER, 0);
        wr(A_INIT, 100); wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_CTRL, ctrl_word(1, 1, 1, 1, 0, 0, 1, 1, 2));

        // directed: upper run needs two periods (R5)
        events(10); tick_once(); step_model(10); check_state("hi first");
        events(10); tick_once(); step_model(10); check_state("hi second");
        // directed: lower run needs three periods (R6)
        for (int i = 0; i < 3; i++) begin
            tick_once(); step_model(0); check_state("lo run");
        end

        // R8 partial and full clear
        wr(A_STAT, 32'h8000_0000); check_state("R8 partial clear");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R8 all ones clears", v, 0);

        // random traffic
        for (int i = 0; i < 40; i++) begin
            int n = $urandom_range(0, 12);
            if (i == 20) wr(A_CTRL, ctrl_word(1, 1, 1, 1, 0, 0, 3, 0, 1));
            if (i % 9 == 4) wr(A_STAT, $urandom);
            events(n); tick_once(); step_model(n); check_state("random");
        end

        // R4 period length
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_PER, 2);
        wr(A_CTRL, 0);
        wr(A_CTRL, ctrl_word(1, 1, 1, 1, 0, 0, 1, 1, 2));
        events(4);
        tick_once(); check_state("R4 tick one");
        tick_once(); check_state("R4 tick two");
        tick_once(); step_model(4); check_state("R4 tick three");
        wr(A_PER, 0);

        // R10 sampling disabled
        wr(A_CTRL, ctrl_word(0, 1, 1, 1, 0, 0, 1, 1, 2));
        events(5); tick_once(); tick_once();
        check_state("R10 master off");
        wr(A_CTRL, ctrl_word(1, 0, 1, 1, 0, 0, 1, 1, 2));
        events(5); tick_once();
        check_state("R10 periodic off");
        wr(A_CTRL, ctrl_word(1, 1, 1, 1, 0, 0, 1, 1, 2));
        tick_once(); step_model(0); check_state("R10 events ignored");

        // R7 and R9 average band
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_INIT, 1000); wr(A_AUP, 500); wr(A_ALO, 0);
        wr(A_CTRL, ctrl_word(1, 1, 0, 0, 1, 0, 1, 7, 7));
        tick_once(); step_model(0); check_state("R7 above band");
        chk("R9 irq from avg above", {31'b0, irq}, 1);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_AUP, 32'hFFFF_FFFF); wr(A_ALO, 600);
        tick_once(); step_model(0); check_state("R7 below band");
        chk("R9 masked avg below", {31'b0, irq}, 0);
        wr(A_CTRL, ctrl_word(1, 1, 0, 0, 1, 1, 1, 7, 7));
        chk("R9 unmasked avg below", {31'b0, irq}, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule